// File: doc/BRIEF.md
# Fixed-Point Differential Equation Integrator with Shared Arithmetic Units

This block numerically steps a second-order differential equation in 16-bit signed Q8.8 fixed point. A single start pulse captures the position `x`, the solution `y`, the derivative `u`, the step size `dx` and the bound `a`. The block then repeats a loop body. Each pass advances `x` by `dx` and recomputes `u` and `y` from the values the pass began with. The loop stops once the advanced `x` is no longer below the bound. The final `y` is then presented together with a one-cycle completion pulse.

All loop arithmetic shares one multiplier and one ALU (add, subtract, signed less-than). A step counter in the controller carries a fixed, hand-derived six-cycle schedule for each pass. No operation starts before its operands exist, and the new `x`, `u` and `y` are committed together on the final step. Overflow wraps silently in two's complement and is not flagged.

Top module: `deq_solver`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `y_o` is 0.
- R2: A `start_i` high while idle captures `x_i`, `y_i`, `u_i`, `dx_i` and `a_i`, and `busy_o` is 1 from the next cycle. A `start_i` high while busy has no effect on the result or on the timing.
- R3: Each pass computes the new position as x + dx, wrapped to 16 bits.
- R4: Each pass computes the new derivative as u − ((3.0·x)·(u·dx)) − ((3.0·y)·dx) from the old x, y and u. Every product is a Q8.8 multiply truncated toward minus infinity (bits 23:8 of the 32-bit product), and every sum wraps to 16 bits.
- R5: Each pass computes the new solution as y + (u·dx) from the old u, with the same product rule.
- R6: The loop continues while the new position is below `a` as a signed compare. The body always runs at least once.
- R7: Each pass takes exactly 6 cycles, so `done_o` rises 6·n clock edges after the start edge for n passes.
- R8: `done_o` is high for exactly one cycle. In that cycle `busy_o` is 0 and `y_o` holds the final solution.
- R9: The solution register changes only on a pass's last step or on a start. `y_o` stays constant within a pass and after completion until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| x_i | input | 16 | Initial position, Q8.8 signed |
| y_i | input | 16 | Initial solution, Q8.8 signed |
| u_i | input | 16 | Initial derivative, Q8.8 signed |
| dx_i | input | 16 | Step size, Q8.8 signed |
| a_i | input | 16 | Loop bound, Q8.8 signed |
| busy_o | output | 1 | High while the loop runs |
| done_o | output | 1 | One-cycle completion pulse |
| y_o | output | 16 | Solution register, Q8.8 signed |

## Verification
The assertions check several properties on every cycle:
- A start is accepted only while idle.
- The step counter advances by one through each pass, and commits occur only on the last step.
- A commit leads either to a new pass or to a single-cycle done pulse with busy low.
- The solution register holds still between commits.

Only the bench scenarios can show that the arithmetic is right: the truncating product order, the use of old values, the wrapping sums and the signed bound compare. The bench compares the final `y_o` and the start-to-done latency against a fixed-point model of its own. It does this across a sweep of start points, step sizes, bounds (including a bound equal to the first new position and a bound already passed) and initial values, and it injects stray starts during busy passes.

// File: rtl/deq_pkg.sv
package deq_pkg;
  localparam int QW    = 16;
  localparam int QF    = 8;
  localparam int NSTEP = 6;
  localparam int SW    = $clog2(NSTEP);

  typedef logic signed [QW-1:0] q_t;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_LT} alu_op_e;

  localparam q_t Q_THREE = q_t'(3 <<< QF);

  // Q-format product, truncated toward minus infinity
  function automatic q_t q_mul(q_t a, q_t b);
    logic signed [2*QW-1:0] p;
    p = a * b;
    return p[QF+QW-1:QF];
  endfunction

  function automatic q_t q_alu(alu_op_e op, q_t a, q_t b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      default: return {{(QW-1){1'b0}}, (a < b)};
    endcase
  endfunction
endpackage

// File: rtl/deq_mul.sv
module deq_mul
  import deq_pkg::*;
(
  input  q_t a_i,
  input  q_t b_i,
  output q_t p_o
);
  assign p_o = q_mul(a_i, b_i);
endmodule

// File: rtl/deq_alu.sv
module deq_alu
  import deq_pkg::*;
(
  input  alu_op_e op_i,
  input  q_t      a_i,
  input  q_t      b_i,
  output q_t      r_o
);
  assign r_o = q_alu(op_i, a_i, b_i);
endmodule

// File: rtl/deq_ctrl.sv
module deq_ctrl
  import deq_pkg::*;
#(
  parameter int STEPS = NSTEP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cont_i,
  output logic [SW-1:0] step_o,
  output logic          busy_o,
  output logic          load_o,
  output logic          commit_o,
  output logic          done_o
);
  logic          run_q;
  logic          done_q;
  logic [SW-1:0] step_q;
  logic          last_w;

  assign last_w   = run_q && (step_q == SW'(STEPS - 1));
  assign load_o   = start_i && !run_q;
  assign commit_o = last_w;
  assign busy_o   = run_q;
  assign step_o   = step_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_w && !cont_i;
      if (load_o) begin
        run_q  <= 1'b1;
        step_q <= '0;
      end else if (run_q) begin
        if (last_w) begin
          step_q <= '0;
          run_q  <= cont_i;
        end else begin
          step_q <= step_q + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/deq_solver.sv
module deq_solver
  import deq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [QW-1:0] x_i,
  input  logic signed [QW-1:0] y_i,
  input  logic signed [QW-1:0] u_i,
  input  logic signed [QW-1:0] dx_i,
  input  logic signed [QW-1:0] a_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic signed [QW-1:0] y_o
);
  // architectural state
  q_t x_q, y_q, u_q, dx_q, a_q;
  // intermediate results
  q_t ma_q, mb_q, x1_q, y1_q, d_q;
  logic c_q;

  // named internal events
  logic          load_w;
  logic          commit_w;
  logic [SW-1:0] step_w;

  q_t      mul_a, mul_b, mul_p;
  alu_op_e alu_op;
  q_t      alu_a, alu_b, alu_r;

  deq_ctrl #(.STEPS(NSTEP)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cont_i   (c_q),
    .step_o   (step_w),
    .busy_o   (busy_o),
    .load_o   (load_w),
    .commit_o (commit_w),
    .done_o   (done_o)
  );

  deq_mul u_mul (.a_i(mul_a), .b_i(mul_b), .p_o(mul_p));
  deq_alu u_alu (.op_i(alu_op), .a_i(alu_a), .b_i(alu_b), .r_o(alu_r));

  // schedule: operand selection per step
  always_comb begin
    mul_a  = Q_THREE;
    mul_b  = x_q;
    alu_op = ALU_ADD;
    alu_a  = x_q;
    alu_b  = dx_q;
    case (step_w)
      SW'(1): begin
        mul_a = u_q;   mul_b = dx_q;
        alu_op = ALU_LT; alu_a = x1_q; alu_b = a_q;
      end
      SW'(2): begin
        mul_a = ma_q;  mul_b = mb_q;
        alu_a = y_q;   alu_b = mb_q;
      end
      SW'(3): begin
        mul_b = y_q;
        alu_op = ALU_SUB; alu_a = u_q; alu_b = ma_q;
      end
      SW'(4): begin
        mul_a = ma_q;  mul_b = dx_q;
      end
      SW'(5): begin
        alu_op = ALU_SUB; alu_a = d_q; alu_b = ma_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      x_q <= '0; y_q <= '0; u_q <= '0; dx_q <= '0; a_q <= '0;
      ma_q <= '0; mb_q <= '0; x1_q <= '0; y1_q <= '0; d_q <= '0;
      c_q <= 1'b0;
    end else if (load_w) begin
      x_q  <= x_i;
      y_q  <= y_i;
      u_q  <= u_i;
      dx_q <= dx_i;
      a_q  <= a_i;
    end else if (busy_o) begin
      case (step_w)
        SW'(0): begin ma_q <= mul_p; x1_q <= alu_r; end
        SW'(1): begin mb_q <= mul_p; c_q  <= alu_r[0]; end
        SW'(2): begin ma_q <= mul_p; y1_q <= alu_r; end
        SW'(3): begin ma_q <= mul_p; d_q  <= alu_r; end
        SW'(4): begin ma_q <= mul_p; end
        default: begin
          x_q <= x1_q;
          y_q <= y1_q;
          u_q <= alu_r;
        end
      endcase
    end
  end

  assign y_o = y_q;
endmodule

// File: rtl/deq_solver_chk.sv
module deq_solver_chk
  import deq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 load,
  input logic                 commit,
  input logic                 cond,
  input logic signed [QW-1:0] y,
  input logic [SW-1:0]        step
);
  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_commit_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (step == SW'(NSTEP - 1)));

  p_step_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> (busy && step == $past(step) + SW'(1)));

  p_loop_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cond) |=> (done && !busy));

  p_loop_again_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cond) |=> (busy && step == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_y_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !load) |=> $stable(y));
endmodule

bind deq_solver deq_solver_chk u_chk (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .start  (start_i),
  .busy   (busy_o),
  .done   (done_o),
  .load   (load_w),
  .commit (commit_w),
  .cond   (c_q),
  .y      (y_o),
  .step   (step_w)
);

// File: tb/deq_solver_tb_top.sv
`timescale 1ns/1ps
module deq_solver_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [15:0] x_in = '0, y_in = '0, u_in = '0, dx_in = '0, a_in = '0;
  logic busy, done;
  logic signed [15:0] y_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  deq_solver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .x_i(x_in), .y_i(y_in), .u_i(u_in), .dx_i(dx_in), .a_i(a_in),
    .busy_o(busy), .done_o(done), .y_o(y_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // floor((a*b)/256), done by division with explicit floor correction
  function automatic logic signed [15:0] qm(input int a, input int b);
    int p, r;
    p = a * b;
    r = ((p % 256) + 256) % 256;
    return 16'((p - r) / 256);
  endfunction

  task automatic model(input int x0, y0, u0, dx, a, output int yf, output int n);
    logic signed [15:0] x, y, u, x1, u1, y1, dxs, as;
    x = 16'(x0); y = 16'(y0); u = 16'(u0); dxs = 16'(dx); as = 16'(a);
    n = 0;
    forever begin
      x1 = x + dxs;
      u1 = u - qm(qm(768, x), qm(u, dxs)) - qm(qm(768, y), dxs);
      y1 = y + qm(u, dxs);
      x = x1; u = u1; y = y1;
      n++;
      if (!(x1 < as) || n >= 30) break;
    end
    yf = int'(y);
  endtask

  task automatic run(input int x0, y0, u0, dx, a, input bit poke);
    int ye, n, cnt;
    model(x0, y0, u0, dx, a, ye, n);
    @(negedge clk);
    x_in = 16'(x0); y_in = 16'(y0); u_in = 16'(u0); dx_in = 16'(dx); a_in = 16'(a);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x_in = 16'sd99; y_in = 16'sd5; u_in = -16'sd7; a_in = 16'sd1;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    cnt = 0;
    while (!done && cnt < 400) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 2) begin start = 1'b1; x_in = 16'sd3000; y_in = -16'sd900; end
      if (poke && cnt == 3) start = 1'b0;
    end
    chk(cnt == 6 * n, poke ? "R2 stray start latency" : "R3,R6,R7 latency", cnt, 6 * n);
    chk(int'(y_out) == ye, poke ? "R2 stray start result" : "R4,R5 final y", int'(y_out), ye);
    chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(int'(y_out) == ye, "R9 y held after done", int'(y_out), ye);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int xs[4]  = '{-512, -64, 0, 200};
    int dxs[3] = '{16, 100, 256};
    int vs[2]  = '{-128, 77};
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(y_out == 16'sd0, "R1 y reset", int'(y_out), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3; j++)
        for (int k = 0; k < 5; k++)
          for (int v = 0; v < 4; v++) begin
            int aoff;
            case (k)
              0: aoff = -300;
              1: aoff = 1;
              2: aoff = dxs[j];
              3: aoff = dxs[j] + 1;
              default: aoff = 3 * dxs[j] + 5;
            endcase
            run(xs[i], vs[v % 2], vs[v / 2], dxs[j], xs[i] + aoff, 1'b0);
          end
    run(-64, 77, -128, 100, 300, 1'b1);
    run(0, 40, 30, 16, 100, 1'b1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule